// File: doc/BRIEF.md
# Synchronous Rectifier On-Time Clamp

This block derives two synchronous-rectifier gate drives from two primary PWM phases, usually driven in complementary fashion. Each gate output copies its primary phase while that phase is high, but only up to a programmable number of clock cycles per pulse. A per-phase counter measures how long the phase has been high. When the counter reaches the clamp value, the gate output is cut off.

The clamp value is never written directly into the live compare registers. Software first places the new value in a staging register through a small write port. It then opens a transfer gate. While the gate is open, each rising edge of phase 0 copies the staging value into the compare registers of both phases on the same clock edge. The recommended update order is: close the gate, write the staging value, then reopen the gate. Following this order means a value that is only partly written can never reach the compare logic.

Top module: `sr_clamp`

## Requirements
- R1: After reset, both compare values hold the all-ones code, the transfer gate is closed and the staging register is 0. With a primary phase low, its gate output is low.
- R2: A rising edge on a primary phase restarts that phase's count at 0 in the same cycle. If the compare value is non-zero, the gate output is high in that first cycle.
- R3: While a primary phase is high, its gate output is high in exactly the first min(H, M) cycles of the pulse, where H is the high time in cycles and M is the active compare value.
- R4: A gate output is low in every cycle in which its primary phase is low, with no delay.
- R5: A compare value of 0 keeps the gate output low for the entire pulse.
- R6: A compare value equal to or greater than the pulse high time makes the gate output an exact copy of the primary phase.
- R7: The per-phase count stops at the all-ones code and does not wrap. With the all-ones compare value, a pulse longer than that code ends its gate output after 2^CW-1 cycles, and the output stays low for the rest of the pulse.
- R8: The write port behaves as follows. A write with `wr_addr`=0 loads `wr_data` into the staging register. A write with `wr_addr`=1 sets the transfer gate to `wr_data[0]`. Writes take effect at the next clock edge.
- R9: A transfer takes place only in a cycle where the gate register is 1 and phase 0 has a rising edge. A transfer loads both compare values on the same clock edge. While the gate register is 0, the compare values do not change.
- R10: The cycle that holds the phase-0 rising edge is still compared against the old value. The transferred value applies from the following cycle. A write to the staging register or to the gate in that same cycle does not affect that transfer.
- R11: While the gate remains 1, every phase-0 rising edge reloads the staging register. A value staged while the gate is open is therefore picked up at the next phase-0 rising edge.
- R12: A rising edge on phase 1 alone never causes a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm0 | input | 1 | Primary PWM, phase 0 (its rising edge is the transfer point) |
| pwm1 | input | 1 | Primary PWM, phase 1 |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 1 | 0 = staging register, 1 = transfer gate |
| wr_data | input | CW | Write data |
| sr0 | output | 1 | Rectifier gate drive, phase 0 |
| sr1 | output | 1 | Rectifier gate drive, phase 1 |

## Verification
The assertions check several properties on every cycle. Each gate output stays low while its phase is low. A zero compare value forces the output off. Both compare values move in lockstep. A closed gate, or a cycle with no phase-0 rising edge, leaves the compare values untouched. The first cycle of a pulse drives the output when the compare value is non-zero. A saturated count stays saturated.

Some behaviours only the bench's scenarios can show: the exact pulse length for a given clamp, the one-cycle delay before a transferred value applies, reloading at every phase-0 rising edge while the gate is open, and the saturation limit on a very long pulse. To cover these, the bench runs a behavioural model of the pulse timing and the staging protocol and compares against it every cycle.

// File: rtl/sr_clamp.sv
module sr_clamp #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwm0,
  input  logic          pwm1,
  input  logic          wr_en,
  input  logic          wr_addr,
  input  logic [CW-1:0] wr_data,
  output logic          sr0,
  output logic          sr1
);
  localparam logic [CW-1:0] TOP = {CW{1'b1}};

  logic [1:0]    pwm, rise, sr;
  logic          pwm_q [2];
  logic [CW-1:0] cnt   [2];
  logic [CW-1:0] match [2];
  logic [CW-1:0] hold;
  logic          gate, xfer;

  assign pwm  = {pwm1, pwm0};
  assign xfer = gate & rise[0];
  assign sr0  = sr[0];
  assign sr1  = sr[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold <= '0;
      gate <= 1'b0;
    end else if (wr_en) begin
      if (wr_addr) gate <= wr_data[0];
      else         hold <= wr_data;
    end
  end

  for (genvar i = 0; i < 2; i++) begin : g_ph
    logic [CW-1:0] cnt_now;

    assign rise[i]  = pwm[i] & ~pwm_q[i];
    assign cnt_now  = rise[i] ? '0 : cnt[i];
    assign sr[i]    = pwm[i] & (cnt_now < match[i]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pwm_q[i] <= 1'b0;
        cnt[i]   <= '0;
        match[i] <= TOP;
      end else begin
        pwm_q[i] <= pwm[i];
        if (pwm[i] && cnt_now != TOP) cnt[i] <= cnt_now + 1'b1;
        else if (pwm[i])              cnt[i] <= TOP;
        if (xfer) match[i] <= hold;
      end
    end
  end
endmodule

// File: rtl/sr_clamp_chk.sv
module sr_clamp_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pwm0,
  input logic          pwm1,
  input logic          sr0,
  input logic          sr1,
  input logic          gate,
  input logic          q0,
  input logic [CW-1:0] m0,
  input logic [CW-1:0] m1,
  input logic [CW-1:0] c0
);
  localparam logic [CW-1:0] TOP = {CW{1'b1}};

  AST_OFF_WHEN_LOW0: assert property (@(posedge clk) disable iff (!rst_n) !pwm0 |-> !sr0); // R4
  AST_OFF_WHEN_LOW1: assert property (@(posedge clk) disable iff (!rst_n) !pwm1 |-> !sr1); // R4
  AST_ZERO_CLAMP: assert property (@(posedge clk) disable iff (!rst_n) (m0 == '0) |-> !sr0); // R5
  AST_LOCKSTEP: assert property (@(posedge clk) disable iff (!rst_n) m0 == m1); // R9
  AST_GATE_CLOSED: assert property (@(posedge clk) disable iff (!rst_n) !gate |=> $stable(m0)); // R9
  AST_NO_EDGE_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n) !(pwm0 && !q0) |=> $stable(m1)); // R12
  AST_FIRST_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) (pwm0 && !q0 && m0 != '0) |-> sr0); // R2
  AST_SATURATE: assert property (@(posedge clk) disable iff (!rst_n) (c0 == TOP && pwm0 && q0) |=> c0 == TOP); // R7
endmodule

bind sr_clamp sr_clamp_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwm0(pwm0), .pwm1(pwm1), .sr0(sr0), .sr1(sr1),
  .gate(gate), .q0(pwm_q[0]), .m0(match[0]), .m1(match[1]), .c0(cnt[0])
);

// File: tb/sim_sr_clamp.sv
`timescale 1ns/1ps
module sim_sr_clamp;
  logic clk = 0, rst_n = 0;
  logic pwm0 = 0, pwm1 = 0, wr_en = 0, wr_addr = 0;
  logic [15:0] wr_data = '0;
  logic sr0, sr1;

  sr_clamp u0 (.clk(clk), .rst_n(rst_n), .pwm0(pwm0), .pwm1(pwm1), .wr_en(wr_en),
               .wr_addr(wr_addr), .wr_data(wr_data), .sr0(sr0), .sr1(sr1));

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  string req = "R1";
  int ela [2] = '{0, 0};
  bit prv [2] = '{0, 0};
  int mdl_match = 65535, mdl_hold = 0;
  bit mdl_gate = 0;

  task automatic cyc(bit p0, bit p1, bit we = 0, bit wa = 0, int wd = 0);
    bit r0;
    @(negedge clk);
    pwm0 = p0; pwm1 = p1; wr_en = we; wr_addr = wa; wr_data = wd[15:0];
    #1;
    r0 = p0 && !prv[0];
    for (int i = 0; i < 2; i++) begin
      bit p, got, expv;
      int el;
      p = (i == 0) ? p0 : p1;
      el = (p && !prv[i]) ? 0 : ela[i];
      expv = p && (el < mdl_match);
      got = (i == 0) ? sr0 : sr1;
      checks++;
      if (got !== expv) begin
        errors++;
        $display("FAIL %s sr%0d at %0t: got %b expected %b", req, i, $time, got, expv);
      end
      if (p) ela[i] = (el + 1 > 65535) ? 65535 : el + 1;
      prv[i] = p;
    end
    if (mdl_gate && r0) mdl_match = mdl_hold;
    if (we) begin
      if (wa) mdl_gate = wd[0];
      else    mdl_hold = wd & 16'hFFFF;
    end
  endtask

  task automatic period(int hi, int lo);
    for (int k = 0; k < hi; k++) cyc(1, 0);
    for (int k = 0; k < lo; k++) cyc(0, 1);
  endtask

  task automatic wr(bit a, int d);
    cyc(0, 1, 1, a, d);
  endtask

  initial begin
    #2_500_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    req = "R1"; cyc(0, 0); cyc(0, 0);
    req = "R1"; period(20, 20);
    req = "R8"; wr(0, 5);
    req = "R9"; period(12, 12); period(12, 12);
    req = "R8"; wr(1, 1);
    req = "R10"; period(12, 12);
    req = "R3"; period(12, 12); period(3, 7);
    req = "R2"; period(1, 4);
    req = "R4"; period(4, 4);
    req = "R11"; wr(0, 30); period(12, 12);
    req = "R6"; period(25, 5); period(30, 5); period(31, 5);
    req = "R11"; wr(0, 0);
    req = "R5"; period(10, 10); period(10, 10);
    req = "R12"; wr(0, 2);
    for (int k = 0; k < 3; k++) begin cyc(0, 0); cyc(0, 1); cyc(0, 1); cyc(0, 1); end
    period(8, 8);
    req = "R10"; wr(1, 0);
    cyc(1, 0, 1, 0, 9); period(6, 6);
    cyc(1, 0, 1, 1, 1); period(6, 6);
    req = "R9"; cyc(1, 0, 1, 0, 3); period(12, 12);
    req = "R9"; period(12, 12);
    req = "R7"; wr(1, 0); wr(0, 16'hFFFF); wr(1, 1); period(4, 4); wr(1, 0);
    period(66000, 6);
    req = "R4"; period(5, 5);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule